// File: doc/BRIEF.md
# Sync-Driven Addend Frequency Compensator

This block works out the 32-bit increment (the addend) for a slave time counter that advances by accumulating a fixed-point step on every local clock. At start-up it derives a first addend from a configured frequency division ratio. After that it receives one sample per Sync event. Each sample carries three values: the master's send timestamp, the assumed one-way path delay and the slave's local receive timestamp. The block keeps the previous sample as a baseline. It measures how far the master and the slave each advanced between the two samples, forms a fixed-point scale factor from those counts, and multiplies the factor into the previous addend. Repeated Sync events pull the addend toward the master's rate, so an early error is corrected over later cycles.

Samples arrive on a valid/ready handshake. A sample is taken only on a clock where both `smp_valid` and `smp_ready` are high. The source must hold the sample stable while `smp_ready` is low. `smp_ready` stays low after reset until the first addend has been produced, and it stays low for the whole of each division and multiplication. The output side has no back-pressure. `addend_valid` pulses for one cycle, and `addend` holds its value until the next pulse.

Top module: `ptp_addend_calc`

## Requirements
- R1: After reset the block produces floor(2^32 / ratio) from `cfg_div_ratio` and pulses `addend_valid` with it. A result that does not fit in 32 bits gives 0xFFFFFFFF, and so does a ratio of 0 or 1. `smp_ready` is low until this pulse.
- R2: A sample is accepted only when `smp_valid` and `smp_ready` are both high. From the cycle after a sample that starts an update until the cycle that carries its `addend_valid`, `smp_ready` is low.
- R3: The first sample accepted after reset only sets the baseline. It gives no `addend_valid` and no `cnt_err`, and `smp_ready` stays high.
- R4: The master count is (send + delay) of this sample minus (send + delay) of the baseline. The slave count is this receive time minus the baseline receive time. Both are taken modulo 2^64, so a timestamp that wraps still gives the true interval. Every accepted sample becomes the new baseline.
- R5: The scale factor is floor(((2·master − slave) mod 2^64) · 2^32 / slave), where master and slave are the two counts. It is an unsigned 32.32 value and saturates to 2^64 − 1.
- R6: The new addend is floor(scale · previous addend / 2^32). It saturates to 0xFFFFFFFF.
- R7: A slave count of zero starts no update and gives no `addend_valid`. `cnt_err` is high for exactly the one cycle after the acceptance, and the sample still becomes the baseline.
- R8: `addend_valid` is a one-cycle pulse, and `addend` does not change between pulses.
- R9: Each update reaches `addend_valid` within 200 cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div_ratio | input | 32 | Division ratio used for the start-up addend |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Block can take a sample |
| smp_sync_ts | input | 64 | Master send time, ns |
| smp_path_delay | input | 64 | Assumed master-to-slave delay, ns |
| smp_rx_ts | input | 64 | Slave receive time, ns |
| addend_valid | output | 1 | New addend on `addend` this cycle |
| addend | output | 32 | Current addend |
| cnt_err | output | 1 | Zero slave interval, update skipped |

## Verification
The bench drives several corner cases.

A design that computes from the very first sample after reset would raise a spurious `addend_valid`. A design that divides by a zero slave interval would emit an all-ones addend where `cnt_err` is expected. Receive timestamps that cross 2^64 catch any subtraction that is not modular; such a design produces a wildly wrong addend. Intervals that are large or badly skewed push both the quotient and the product past their limits; a design without saturation would truncate them to small values instead of 0xFFFFFFFF. Start-up ratios of 0, 1 and odd values check the rounding of the first addend. `smp_ready` is watched for any sign that a second sample could enter during a computation.

// File: rtl/ptp_addend_pkg.sv
package ptp_addend_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_INIT_DIV,
    ST_IDLE,
    ST_UPD_DIV,
    ST_MUL
  } calc_state_e;

endpackage

// File: rtl/ptp_ts_delta.sv
module ptp_ts_delta #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [TS_W-1:0] sync_ts,
  input  logic [TS_W-1:0] path_delay,
  input  logic [TS_W-1:0] rx_ts,
  output logic            base_ok,
  output logic [TS_W-1:0] slv_cnt,
  output logic [TS_W-1:0] scale_num
);

  logic [TS_W-1:0] prev_mct;
  logic [TS_W-1:0] prev_rx;
  logic [TS_W-1:0] cur_mct;
  logic [TS_W-1:0] mst_cnt;
  logic [TS_W-1:0] diff_cnt;

  always_comb begin
    cur_mct   = sync_ts + path_delay;
    mst_cnt   = cur_mct - prev_mct;
    slv_cnt   = rx_ts - prev_rx;
    diff_cnt  = mst_cnt - slv_cnt;
    scale_num = mst_cnt + diff_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_mct <= '0;
      prev_rx  <= '0;
      base_ok  <= 1'b0;
    end else if (capture) begin
      prev_mct <= cur_mct;
      prev_rx  <= rx_ts;
      base_ok  <= 1'b1;
    end
  end

endmodule

// File: rtl/ptp_restoring_div.sv
module ptp_restoring_div #(
  parameter int N_W    = 64,
  parameter int D_W    = 64,
  parameter int FRAC_W = 32,
  localparam int DV_W  = N_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N_W-1:0]  num,
  input  logic [D_W-1:0]  den,
  output logic            done,
  output logic [DV_W-1:0] quo
);

  localparam int CNT_W = $clog2(DV_W + 1);

  logic [DV_W-1:0]  work;
  logic [D_W-1:0]   rem;
  logic [D_W-1:0]   den_r;
  logic [CNT_W-1:0] step;
  logic             running;
  logic [D_W:0]     rem_sh;
  logic             take;

  always_comb begin
    rem_sh = {rem, work[DV_W-1]};
    take   = rem_sh >= {1'b0, den_r};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work    <= '0;
      rem     <= '0;
      den_r   <= '0;
      step    <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        work    <= {num, {FRAC_W{1'b0}}};
        rem     <= '0;
        den_r   <= den;
        step    <= '0;
        running <= 1'b1;
      end else if (running) begin
        if (take) rem <= rem_sh[D_W-1:0] - den_r;
        else      rem <= rem_sh[D_W-1:0];
        work <= {work[DV_W-2:0], take};
        if (step == CNT_W'(DV_W - 1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
        step <= step + 1'b1;
      end
    end
  end

  assign quo = work;

endmodule

// File: rtl/ptp_shift_mul.sv
module ptp_shift_mul #(
  parameter int A_W  = 64,
  parameter int B_W  = 32,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           done,
  output logic [P_W-1:0] prod
);

  localparam int CNT_W = $clog2(B_W + 1);

  logic [P_W-1:0]   a_sh;
  logic [B_W-1:0]   b_sh;
  logic [P_W-1:0]   acc;
  logic [CNT_W-1:0] step;
  logic             running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sh    <= '0;
      b_sh    <= '0;
      acc     <= '0;
      step    <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        a_sh    <= P_W'(a);
        b_sh    <= b;
        acc     <= '0;
        step    <= '0;
        running <= 1'b1;
      end else if (running) begin
        if (b_sh[0]) acc <= acc + a_sh;
        a_sh <= a_sh << 1;
        b_sh <= b_sh >> 1;
        if (step == CNT_W'(B_W - 1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
        step <= step + 1'b1;
      end
    end
  end

  assign prod = acc;

endmodule

// File: rtl/ptp_addend_calc.sv
module ptp_addend_calc
  import ptp_addend_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int ADD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADD_W-1:0]  cfg_div_ratio,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [TS_W-1:0]   smp_sync_ts,
  input  logic [TS_W-1:0]   smp_path_delay,
  input  logic [TS_W-1:0]   smp_rx_ts,
  output logic              addend_valid,
  output logic [ADD_W-1:0]  addend,
  output logic              cnt_err
);

  localparam int Q_W  = TS_W;
  localparam int DV_W = TS_W + FRAC_W;
  localparam int P_W  = Q_W + ADD_W;

  calc_state_e      state;
  logic [ADD_W-1:0] addend_r;
  logic             valid_r;
  logic             err_r;

  logic             fire;
  logic             base_ok;
  logic [TS_W-1:0]  slv_cnt;
  logic [TS_W-1:0]  scale_num;
  logic             upd_go;
  logic             zero_go;

  logic             div_start;
  logic [TS_W-1:0]  div_num;
  logic [TS_W-1:0]  div_den;
  logic             div_done;
  logic [DV_W-1:0]  div_quo;
  logic [Q_W-1:0]   scale_sat;
  logic [ADD_W-1:0] init_sat;

  logic             mul_start;
  logic             mul_done;
  logic [P_W-1:0]   mul_prod;
  logic [ADD_W-1:0] prod_sat;

  assign smp_ready = (state == ST_IDLE);
  assign fire      = smp_valid && smp_ready;
  assign upd_go    = fire && base_ok && (slv_cnt != '0);
  assign zero_go   = fire && base_ok && (slv_cnt == '0);

  ptp_ts_delta #(.TS_W(TS_W)) delta_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (fire),
    .sync_ts   (smp_sync_ts),
    .path_delay(smp_path_delay),
    .rx_ts     (smp_rx_ts),
    .base_ok   (base_ok),
    .slv_cnt   (slv_cnt),
    .scale_num (scale_num)
  );

  always_comb begin
    div_start = (state == ST_BOOT) || upd_go;
    if (state == ST_BOOT) begin
      div_num = TS_W'(1);
      div_den = TS_W'(cfg_div_ratio);
    end else begin
      div_num = scale_num;
      div_den = slv_cnt;
    end
  end

  ptp_restoring_div #(.N_W(TS_W), .D_W(TS_W), .FRAC_W(FRAC_W)) div_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (div_num),
    .den  (div_den),
    .done (div_done),
    .quo  (div_quo)
  );

  always_comb begin
    scale_sat = (|div_quo[DV_W-1:Q_W])   ? '1 : div_quo[Q_W-1:0];
    init_sat  = (|div_quo[DV_W-1:ADD_W]) ? '1 : div_quo[ADD_W-1:0];
    prod_sat  = (|mul_prod[P_W-1:FRAC_W+ADD_W]) ? '1
                                                : mul_prod[FRAC_W+ADD_W-1:FRAC_W];
    mul_start = (state == ST_UPD_DIV) && div_done;
  end

  ptp_shift_mul #(.A_W(Q_W), .B_W(ADD_W)) mul_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(mul_start),
    .a    (scale_sat),
    .b    (addend_r),
    .done (mul_done),
    .prod (mul_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_BOOT;
      addend_r <= '0;
      valid_r  <= 1'b0;
      err_r    <= 1'b0;
    end else begin
      valid_r <= 1'b0;
      err_r   <= 1'b0;
      unique case (state)
        ST_BOOT:     state <= ST_INIT_DIV;
        ST_INIT_DIV: if (div_done) begin
          addend_r <= init_sat;
          valid_r  <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_IDLE: begin
          if (upd_go)  state <= ST_UPD_DIV;
          if (zero_go) err_r <= 1'b1;
        end
        ST_UPD_DIV:  if (div_done) state <= ST_MUL;
        ST_MUL:      if (mul_done) begin
          addend_r <= prod_sat;
          valid_r  <= 1'b1;
          state    <= ST_IDLE;
        end
        default:     state <= ST_BOOT;
      endcase
    end
  end

  assign addend       = addend_r;
  assign addend_valid = valid_r;
  assign cnt_err      = err_r;

endmodule

// File: rtl/ptp_addend_calc_chk.sv
module ptp_addend_calc_chk #(
  parameter int ADD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             addend_valid,
  input logic [ADD_W-1:0] addend,
  input logic             cnt_err
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    addend_valid |=> !addend_valid); // R8

  AST_ADDEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addend_valid |-> $stable(addend)); // R8

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> !cnt_err); // R7

  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |-> $past(smp_valid && smp_ready)); // R7

  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |-> !addend_valid); // R7

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addend_valid |-> !$past(smp_ready)); // R2

endmodule

bind ptp_addend_calc ptp_addend_calc_chk #(.ADD_W(ADD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .addend_valid(addend_valid),
  .addend      (addend),
  .cnt_err     (cnt_err)
);

// File: tb/ptp_addend_calc_tb_top.sv
module ptp_addend_calc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_div_ratio = 32'd8;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [63:0] smp_sync_ts = '0;
  logic [63:0] smp_path_delay = '0;
  logic [63:0] smp_rx_ts = '0;
  logic        addend_valid;
  logic [31:0] addend;
  logic        cnt_err;

  always #10 clk = ~clk;

  ptp_addend_calc dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_div_ratio (cfg_div_ratio),
    .smp_valid     (smp_valid),
    .smp_ready     (smp_ready),
    .smp_sync_ts   (smp_sync_ts),
    .smp_path_delay(smp_path_delay),
    .smp_rx_ts     (smp_rx_ts),
    .addend_valid  (addend_valid),
    .addend        (addend),
    .cnt_err       (cnt_err)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [31:0] exp_q[$];
  logic [31:0] model_add;
  logic [63:0] m_prev_mct;
  logic [63:0] m_prev_rx;
  bit          m_base;
  bit          exp_err;
  logic [31:0] last_add;
  int          wait_cnt;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] init_expect(logic [31:0] r);
    logic [63:0] q;
    if (r == 0) return 32'hFFFF_FFFF;
    q = 64'h1_0000_0000 / {32'h0, r};
    return (q > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
  endfunction

  function automatic logic [31:0] upd_expect(logic [63:0] mcc, logic [63:0] scc,
                                             logic [31:0] prev);
    logic [63:0]  num;
    logic [127:0] q;
    logic [127:0] p;
    num = (mcc << 1) - scc;                         // R5
    q = {32'h0, num, 32'h0} / {64'h0, scc};
    if (q[127:64] != 0) q = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
    p = q * {96'h0, prev};                          // R6
    p = p >> 32;
    return (p[127:32] != 0) ? 32'hFFFF_FFFF : p[31:0];
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(cnt_err == exp_err, "R7 err flag", {63'h0, cnt_err}, {63'h0, exp_err});
      exp_err = 1'b0;
      if (addend_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R8 unexpected addend_valid", {32'h0, addend}, 64'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(addend == e, "R1/R5/R6 addend value", {32'h0, addend}, {32'h0, e});
        end
        wait_cnt = 0;
      end else begin
        check(addend == last_add, "R8 addend hold", {32'h0, addend}, {32'h0, last_add});
      end
      last_add = addend;
      if (exp_q.size() != 0) begin
        check(!smp_ready, "R1/R2 ready low while busy", {63'h0, smp_ready}, 64'h0);
        wait_cnt++;
        check(wait_cnt < 200, "R9 latency", 64'(wait_cnt), 64'd200);
      end
    end
  end

  task automatic do_reset(logic [31:0] ratio);
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    cfg_div_ratio = ratio;
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(addend == 0 && !addend_valid && !cnt_err && !smp_ready, "R1 reset state",
          {32'h0, addend}, 64'h0);
    model_add = init_expect(ratio);
    exp_q.push_back(model_add);
    m_base = 1'b0;
    last_add = '0;
    wait_cnt = 0;
    exp_err = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic send(logic [63:0] sync_ts, logic [63:0] dly, logic [63:0] rx);
    logic [63:0] mct;
    logic [63:0] mcc;
    logic [63:0] scc;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_sync_ts = sync_ts;
    smp_path_delay = dly;
    smp_rx_ts = rx;
    while (!smp_ready) @(negedge clk);
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    mct = sync_ts + dly;
    mcc = mct - m_prev_mct;                         // R4
    scc = rx - m_prev_rx;
    if (!m_base) begin
      exp_err = 1'b0;                               // R3 baseline only
    end else if (scc == 0) begin
      exp_err = 1'b1;                               // R7
    end else begin
      model_add = upd_expect(mcc, scc, model_add);
      exp_q.push_back(model_add);
    end
    m_base = 1'b1;
    m_prev_mct = mct;
    m_prev_rx = rx;
    @(negedge clk);
    if (exp_q.size() == 0)
      check(smp_ready, "R3/R7 ready stays high", {63'h0, smp_ready}, 64'h1);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, "R9 drain", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 start-up addend under several ratios
    do_reset(32'd8);  drain();
    do_reset(32'd3);  drain();
    do_reset(32'd1);  drain();
    do_reset(32'd0);  drain();
    do_reset(32'd20); drain();

    // R3 R4 R5 R6: drifting slave, constant delay
    begin
      logic [63:0] s = 64'd5_000;
      logic [63:0] r = 64'd6_000;
      send(s, 64'd700, r);
      for (int i = 0; i < 8; i++) begin
        s = s + 64'd1_000_000_000;
        r = r + 64'd1_000_000_000 + 64'(i * 37) - 64'd100;
        send(s, 64'd700, r);
        drain();
      end
    end

    // R7 zero slave interval, then the sample is the baseline
    send(64'd9_000_000_000, 64'd700, 64'd9_000_001_000);
    send(64'd9_500_000_000, 64'd700, 64'd9_000_001_000);
    send(64'd10_500_000_000, 64'd700, 64'd10_000_001_200);
    drain();

    // R9 R4 wrap of receive and send timestamps
    do_reset(32'd50);
    drain();
    send(64'hFFFF_FFFF_FFFF_0000, 64'd300, 64'hFFFF_FFFF_FFFF_F000);
    send(64'h0000_0000_3B9A_0000, 64'd300, 64'h0000_0000_3B9A_EF00);
    drain();
    send(64'h0000_0000_7735_0000, 64'd300, 64'h0000_0000_7735_E000);
    drain();

    // R5 R6 saturation: master runs far ahead, then far behind
    send(64'h0000_0010_0000_0000, 64'd0, 64'h0000_0000_7735_E010);
    drain();
    send(64'h0000_0010_0000_0000, 64'd0, 64'h0000_0100_0000_0000);
    drain();
    send(64'h0000_0010_0000_1000, 64'd0, 64'h0000_0100_0000_0100);
    drain();

    // R2 back-to-back offered samples
    do_reset(32'd4);
    for (int i = 0; i < 4; i++)
      send(64'(i) * 64'd125_000_000, 64'd50, 64'(i) * 64'd125_000_013 + 64'd9);
    drain();

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule